// File: doc/BRIEF.md
# Per-Channel Converter Parameter Serial Loader

This block sits between a host register bus and a daisy chain of serial DACs that set the pedestal, linearity, gain and one auxiliary setting of each converter channel. The host first writes a transfer address register; a six-bit field inside that address picks one of 64 channels. It then writes a parameter word that packs four six-bit settings. If loading has been enabled in the control register and no load is running, the block sends a frame on a three-wire serial link. The frame carries the channel number, then the four settings. A latch pulse follows it.

The control register uses separate bit positions to set and to clear the enable. It shows a busy flag for as long as a frame is on the wire, so the host polls it before it loads the next channel. A parameter write that cannot be accepted is dropped and leaves a sticky error flag. Two reset bits are provided. One clears everything, including the control register. The other clears the address and parameter registers and any frame in flight, but keeps the control register.

Top module: `chanpar_loader`

## Requirements
- R1: After reset every register reads 0, and ser_clk, ser_dat and ser_latch are 0.
- R2: Register select 0 is the control register. Writing a 1 to bit 12 enables loading, and bit 12 reads back 1 while loading is enabled. Writing a 1 to bit 29 disables loading. When bits 12 and 29 are written as 1 together, the disable wins.
- R3: A write to register select 2 while loading is enabled and idle starts a 30-bit frame. The frame is the channel (address register bits 14:9) followed by parameter bits 23:0, most significant bit first. Bits 23:18 hold pedestal, 17:12 linearity, 11:6 gain and 5:0 the auxiliary setting.
- R4: Each frame bit lasts 4 system cycles. ser_clk is low for the first 2 cycles of a bit and high for the last 2, and ser_dat is stable while ser_clk is high. After the last bit, ser_latch is high for 4 cycles while ser_clk stays low.
- R5: Control bit 13 reads 1 from the cycle after an accepted parameter write until the latch pulse ends, which is 124 cycles in total.
- R6: A parameter write made while loading is disabled or busy is dropped. No frame is sent, the parameter register keeps its value, and control bit 0 is set and stays set.
- R7: Writing a 1 to control bit 30 clears the enable, the error flag, the address and parameter registers, and any frame in progress; no latch pulse follows.
- R8: Writing a 1 to control bit 31 (without bit 30) clears the address and parameter registers and aborts any frame in progress, while the enable and error bits keep their values.
- R9: Register select 1 reads the 32-bit address register, select 2 reads the accepted parameter word in bits 23:0, and select 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Register write strobe, one cycle per write |
| host_sel | input | 2 | Register select: 0 control, 1 address, 2 parameter, 3 none |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data of the selected register (combinational) |
| ser_clk | output | 1 | Serial clock to the DAC chain |
| ser_dat | output | 1 | Serial data, sampled by the receiver on the rising ser_clk |
| ser_latch | output | 1 | Latch pulse after the last bit of a frame |

## Verification
The bench builds the block with its default parameters: a 6-bit channel field at bit 9, four 6-bit settings, a divide-by-4 serial clock and most-significant-bit-first order. With a 30-bit frame, one load takes 124 cycles. That is short enough to run many randomized loads, plus the end values of channel 63 with an all-ones word and channel 0 with all zeros. The same timing makes it possible to land a rejected write, or a soft or full reset, in the middle of a frame and confirm that the chain never latches.

// File: rtl/chanpar_pkg.sv
package chanpar_pkg;
   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_ADDR = 2'd1,
      SEL_PARM = 2'd2,
      SEL_NONE = 2'd3
   } regsel_e;

   // control register bit positions (fixed by host software)
   localparam int CB_ERR     = 0;
   localparam int CB_EN      = 12;
   localparam int CB_BUSY    = 13;
   localparam int CB_DIS     = 29;
   localparam int CB_RST_ALL = 30;
   localparam int CB_RST_REG = 31;

   typedef enum logic [1:0] {
      SH_IDLE  = 2'd0,
      SH_SHIFT = 2'd1,
      SH_LATCH = 2'd2
   } shstate_e;
endpackage

// File: rtl/chanpar_regs.sv
module chanpar_regs
   import chanpar_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int CHAN_W   = 6,
   parameter int CHAN_LSB = 9,
   parameter int PARM_W   = 24,
   localparam int FRAME_W = CHAN_W + PARM_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [1:0]         sel,
   input  logic [DATA_W-1:0]  wdata,
   input  logic               busy,
   output logic               en,
   output logic               err,
   output logic               start,
   output logic               abort,
   output logic [FRAME_W-1:0] frame,
   output logic [DATA_W-1:0]  rdata
);
   logic [DATA_W-1:0] addr_q;
   logic [PARM_W-1:0] parm_q;
   logic ctl_wr, parm_wr, rst_all, rst_reg;

   assign ctl_wr  = wr && (regsel_e'(sel) == SEL_CTRL);
   assign parm_wr = wr && (regsel_e'(sel) == SEL_PARM);
   assign rst_all = ctl_wr && wdata[CB_RST_ALL];
   assign rst_reg = ctl_wr && wdata[CB_RST_REG] && !wdata[CB_RST_ALL];
   assign abort   = rst_all || rst_reg;
   assign start   = parm_wr && en && !busy;
   assign frame   = {addr_q[CHAN_LSB +: CHAN_W], wdata[PARM_W-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en  <= 1'b0;
         err <= 1'b0;
      end else if (rst_all) begin
         en  <= 1'b0;
         err <= 1'b0;
      end else begin
         if (ctl_wr) begin
            if (wdata[CB_DIS])     en <= 1'b0;
            else if (wdata[CB_EN]) en <= 1'b1;
         end
         if (parm_wr && !start) err <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         parm_q <= '0;
      end else if (abort) begin
         addr_q <= '0;
         parm_q <= '0;
      end else begin
         if (wr && (regsel_e'(sel) == SEL_ADDR)) addr_q <= wdata;
         if (start) parm_q <= wdata[PARM_W-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      unique case (regsel_e'(sel))
         SEL_CTRL: begin
            rdata[CB_ERR]  = err;
            rdata[CB_EN]   = en;
            rdata[CB_BUSY] = busy;
         end
         SEL_ADDR: rdata = addr_q;
         SEL_PARM: rdata[PARM_W-1:0] = parm_q;
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/chanpar_shifter.sv
module chanpar_shifter
   import chanpar_pkg::*;
#(
   parameter int FRAME_W   = 30,
   parameter int DIV       = 4,
   parameter bit MSB_FIRST = 1'b1,
   localparam int PW = (DIV > 2) ? $clog2(DIV) : 1,
   localparam int BW = $clog2(FRAME_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               abort,
   input  logic [FRAME_W-1:0] frame_in,
   output logic               busy,
   output logic               sclk,
   output logic               sdat,
   output logic               slatch
);
   localparam logic [PW-1:0] PH_LAST = PW'(DIV - 1);
   localparam logic [PW-1:0] PH_HIGH = PW'(DIV / 2);
   localparam logic [BW-1:0] BIT_LAST = BW'(FRAME_W - 1);

   shstate_e           st;
   logic [PW-1:0]      phase;
   logic [BW-1:0]      bitn;
   logic [FRAME_W-1:0] sh, sh_nxt;
   logic               out_bit;

   generate
      if (MSB_FIRST) begin : g_msb
         assign out_bit = sh[FRAME_W-1];
         assign sh_nxt  = {sh[FRAME_W-2:0], 1'b0};
      end else begin : g_lsb
         assign out_bit = sh[0];
         assign sh_nxt  = {1'b0, sh[FRAME_W-1:1]};
      end
   endgenerate

   assign busy   = (st != SH_IDLE);
   assign sdat   = (st == SH_SHIFT) && out_bit;
   assign sclk   = (st == SH_SHIFT) && (phase >= PH_HIGH);
   assign slatch = (st == SH_LATCH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= SH_IDLE;
         phase <= '0;
         bitn  <= '0;
         sh    <= '0;
      end else if (abort) begin
         st    <= SH_IDLE;
         phase <= '0;
         bitn  <= '0;
         sh    <= '0;
      end else begin
         unique case (st)
            SH_IDLE: if (start) begin
               st    <= SH_SHIFT;
               sh    <= frame_in;
               phase <= '0;
               bitn  <= '0;
            end
            SH_SHIFT: begin
               phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
               if (phase == PH_LAST) begin
                  if (bitn == BIT_LAST) begin
                     st <= SH_LATCH;
                     sh <= '0;
                  end else begin
                     sh   <= sh_nxt;
                     bitn <= bitn + 1'b1;
                  end
               end
            end
            SH_LATCH: begin
               phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
               if (phase == PH_LAST) st <= SH_IDLE;
            end
            default: st <= SH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/chanpar_loader.sv
module chanpar_loader
   import chanpar_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int CHAN_W    = 6,
   parameter int CHAN_LSB  = 9,
   parameter int FIELD_W   = 6,
   parameter int N_FIELDS  = 4,
   parameter int DIV       = 4,
   parameter bit MSB_FIRST = 1'b1,
   localparam int PARM_W   = FIELD_W * N_FIELDS,
   localparam int FRAME_W  = CHAN_W + PARM_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [1:0]        host_sel,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              ser_clk,
   output logic              ser_dat,
   output logic              ser_latch
);
   generate
      if (DATA_W < 32) begin : g_bad_data
         $error("DATA_W must reach the reset bits at 31");
      end
      if (PARM_W > DATA_W) begin : g_bad_parm
         $error("parameter word wider than the data bus");
      end
      if (CHAN_LSB + CHAN_W > DATA_W) begin : g_bad_chan
         $error("channel field outside the address register");
      end
      if (DIV < 2 || (DIV % 2) != 0) begin : g_bad_div
         $error("DIV must be even and at least 2");
      end
   endgenerate

   logic               busy_w, en_w, err_w, start_w, abort_w;
   logic [FRAME_W-1:0] frame_w;

   chanpar_regs #(
      .DATA_W(DATA_W), .CHAN_W(CHAN_W), .CHAN_LSB(CHAN_LSB), .PARM_W(PARM_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(host_wr), .sel(host_sel),
      .wdata(host_wdata), .busy(busy_w), .en(en_w), .err(err_w),
      .start(start_w), .abort(abort_w), .frame(frame_w), .rdata(host_rdata)
   );

   chanpar_shifter #(
      .FRAME_W(FRAME_W), .DIV(DIV), .MSB_FIRST(MSB_FIRST)
   ) u_shift (
      .clk(clk), .rst_n(rst_n), .start(start_w), .abort(abort_w),
      .frame_in(frame_w), .busy(busy_w), .sclk(ser_clk), .sdat(ser_dat),
      .slatch(ser_latch)
   );
endmodule

// File: rtl/chanpar_loader_chk.sv
module chanpar_loader_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_wr,
   input logic [1:0]        host_sel,
   input logic [DATA_W-1:0] host_wdata,
   input logic              busy,
   input logic              en,
   input logic              err,
   input logic              sclk,
   input logic              sdat,
   input logic              slatch
);
   logic ctl_wr, parm_wr;
   assign ctl_wr  = host_wr && (host_sel == 2'd0);
   assign parm_wr = host_wr && (host_sel == 2'd2);

   AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(en)); // R6
   AST_DROP_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (parm_wr && (!en || busy)) |=> err); // R6
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !(ctl_wr && host_wdata[30])) |=> err); // R6
   AST_FULL_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && host_wdata[30]) |=> (!en && !err && !busy && !slatch)); // R7
   AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && host_wdata[31] && !host_wdata[30])
      |=> (!busy && en == $past(en) && err == $past(err))); // R8
   AST_LATCH_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      slatch |-> (!sclk && busy)); // R4
   AST_DAT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(sdat)); // R4
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!sclk && !sdat && !slatch)); // R5
endmodule

bind chanpar_loader chanpar_loader_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
   .host_wdata(host_wdata), .busy(busy_w), .en(en_w), .err(err_w),
   .sclk(ser_clk), .sdat(ser_dat), .slatch(ser_latch)
);

// File: tb/tb_chanpar_loader.sv
`timescale 1ns/1ps
module tb_chanpar_loader;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic [1:0]  host_sel = 2'd3;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        ser_clk, ser_dat, ser_latch;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   chanpar_loader dut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .ser_clk(ser_clk),
      .ser_dat(ser_dat), .ser_latch(ser_latch)
   );

   // serial receiver model
   logic [31:0] cap;
   int  cap_n = 0, frames = 0, latch_len = 0, hi_run = 0, per = 0;
   logic [31:0] last_frame = '0;
   int  last_bits = 0, last_latch = 0;
   bit  timing_bad = 1'b0;
   int  clr_req = 0, clr_seen = 0;
   logic p_clk = 1'b0, p_lat = 1'b0;

   always @(negedge clk) begin
      if (clr_req != clr_seen) begin
         cap = '0; cap_n = 0; timing_bad = 1'b0; per = 0;
         clr_seen = clr_req;
      end
      per++;
      if (ser_clk && !p_clk) begin
         cap = {cap[30:0], ser_dat};
         if (cap_n > 0 && per != 4) timing_bad = 1'b1;
         per = 0;
         cap_n++;
      end
      if (ser_clk) hi_run++;
      if (!ser_clk && p_clk) begin
         if (hi_run != 2) timing_bad = 1'b1;
         hi_run = 0;
      end
      if (ser_latch && !p_lat) begin
         frames++; last_frame = cap; last_bits = cap_n; latch_len = 0;
         if (ser_clk) timing_bad = 1'b1;
      end
      if (ser_latch) latch_len++;
      if (!ser_latch && p_lat) last_latch = latch_len;
      p_clk = ser_clk;
      p_lat = ser_latch;
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] sel, logic [31:0] d);
      @(negedge clk);
      host_sel = sel; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0; host_wdata = '0;
   endtask

   task automatic rd(logic [1:0] sel, output logic [31:0] d);
      host_sel = sel;
      #1 d = host_rdata;
   endtask

   function automatic logic [31:0] exp_frame(logic [31:0] a, logic [31:0] p);
      return {2'b00, a[14:9], p[23:0]};
   endfunction

   task automatic wait_idle(output int n);
      logic [31:0] d;
      n = 0;
      rd(2'd0, d);
      while (d[13]) begin
         n++;
         @(negedge clk);
         rd(2'd0, d);
      end
   endtask

   task automatic do_load(logic [31:0] a, logic [31:0] p, string tag);
      int n, f0;
      logic [31:0] d;
      wr(2'd1, a);
      clr_req++;
      @(negedge clk);
      f0 = frames;
      wr(2'd2, p);
      wait_idle(n);
      @(negedge clk);
      check({tag, " R5 busy cycles"}, n, 124);
      check({tag, " R3 one frame"}, frames - f0, 1);
      check({tag, " R3 bit count"}, last_bits, 30);
      check({tag, " R3 frame"}, last_frame, exp_frame(a, p));
      check({tag, " R4 latch width"}, last_latch, 4);
      check({tag, " R4 clock shape"}, timing_bad, 0);
      rd(2'd2, d);
      check({tag, " R9 param readback"}, d, {8'h0, p[23:0]});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d, a, p;
      int f0, n;
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd(2'd0, d); check("R1 ctrl reset", d, 0);
      rd(2'd1, d); check("R1 addr reset", d, 0);
      rd(2'd2, d); check("R1 param reset", d, 0);
      check("R1 serial idle", {29'd0, ser_clk, ser_dat, ser_latch}, 0);
      rd(2'd3, d); check("R9 sel3 reads zero", d, 0);

      // R6 dropped while disabled
      f0 = frames;
      wr(2'd2, 32'h00AB_CDEF);
      repeat (130) @(negedge clk);
      check("R6 no frame when disabled", frames - f0, 0);
      rd(2'd0, d); check("R6 error set", d, 32'h1);
      rd(2'd2, d); check("R6 param kept", d, 0);

      // R7 full reset clears error
      wr(2'd0, 32'h4000_0000);
      rd(2'd0, d); check("R7 ctrl cleared", d, 0);

      // R2 enable / disable
      wr(2'd0, 32'h0000_1000);
      rd(2'd0, d); check("R2 enable reads back", d, 32'h1000);
      wr(2'd0, 32'h2000_1000);
      rd(2'd0, d); check("R2 disable wins", d, 0);
      wr(2'd0, 32'h0000_1000);

      // R3 directed corners
      do_load(32'hFFFF_FFFF, 32'hFFFF_FFFF, "ch63 ones");
      do_load(32'h0000_0000, 32'h0000_0000, "ch0 zeros");
      do_load(32'h0000_0200, 32'h0080_0001, "ch1 edge");
      rd(2'd1, d); check("R9 addr readback", d, 32'h0000_0200);

      // R6 dropped while busy
      a = 32'h0000_5400; p = 32'h0012_3456;
      wr(2'd1, a);
      clr_req++;
      @(negedge clk);
      f0 = frames;
      wr(2'd2, p);
      repeat (10) @(negedge clk);
      wr(2'd2, 32'h00FF_0000);
      wait_idle(n);
      @(negedge clk);
      check("R6 only first frame", frames - f0, 1);
      check("R6 first frame intact", last_frame, exp_frame(a, p));
      rd(2'd2, d); check("R6 param not overwritten", d, p);
      rd(2'd0, d); check("R6 error sticky with enable", d, 32'h1001);

      // R8 soft reset mid-frame
      clr_req++;
      wr(2'd1, 32'h0000_3E00);
      f0 = frames;
      wr(2'd2, 32'h0055_AA55);
      repeat (20) @(negedge clk);
      wr(2'd0, 32'h8000_0000);
      rd(2'd0, d); check("R8 ctrl kept, not busy", d, 32'h1001);
      rd(2'd1, d); check("R8 addr cleared", d, 0);
      rd(2'd2, d); check("R8 param cleared", d, 0);
      repeat (130) @(negedge clk);
      check("R8 no latch after abort", frames - f0, 0);

      // R7 full reset mid-frame
      clr_req++;
      wr(2'd1, 32'h0000_1200);
      f0 = frames;
      wr(2'd2, 32'h0011_2233);
      repeat (50) @(negedge clk);
      wr(2'd0, 32'h4000_0000);
      rd(2'd0, d); check("R7 ctrl cleared mid-frame", d, 0);
      rd(2'd2, d); check("R7 param cleared", d, 0);
      repeat (130) @(negedge clk);
      check("R7 no latch after abort", frames - f0, 0);

      // random loads
      wr(2'd0, 32'h0000_1000);
      for (int i = 0; i < 40; i++) begin
         a = $urandom; p = $urandom;
         do_load(a, p, "random");
      end
      rd(2'd0, d); check("R6 no error from good loads", d, 32'h1000);

      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule